// File: doc/BRIEF.md
# ADC Power-Up Calibration Sequencer

This block brings a serial 12-bit-plus-sign converter into a usable state after reset. On a start request it sends a self-calibration command and then one status read, whose answer is thrown away. It then waits for the converter's end-of-conversion line to rise, with a bounded wait. It reads the status word a second time and checks that calibration has finished. If it has, it programs the sample-and-hold acquisition time. Each byte goes to an external byte-wide SPI shifter through a request/acknowledge handshake. A frame-end flag tells the shifter when to release chip select.

The converter has two variants. The reduced-channel variant expects its command fields at different bit positions, so every byte sent to it is remapped. The run ends with a one-cycle done pulse, or with a one-cycle error pulse when calibration is still busy or the acquisition selection is not supported. Bit-level shifting and the conversion clock belong to other blocks.

Top module: `adc_init_seq`

## Requirements
- R1: After synchronous reset, spi_req_o, done_o and err_o are low, and no byte is requested until start_i is seen high in the idle state.
- R2: A run on the full variant requests, in this order: 0x08 (frame end); 0x0C then 0x00 (frame end); a wait; 0x0C then 0x00 (frame end); and the acquisition command (frame end). spi_last_o is high exactly on the frame-end bytes.
- R3: The byte received during the first status frame has no effect: a run whose first read reports calibration busy still completes with done_o.
- R4: The wait ends at the first rising edge of eoc_i after the wait begins. If no edge arrives, it ends after TIMEOUT_CYC cycles. Reaching the timeout is not an error by itself, and the next status read is requested TIMEOUT_CYC+1 cycles after the acknowledge of the frame before the wait.
- R5: The status word is {first received byte, bit 7 of the second received byte}. If its bit 6 (bit 5 of the first byte) is set, err_o pulses and no acquisition command is sent. No other status bit affects the result.
- R6: acq_sel_i selects the acquisition command: 6 gives 0x0E, 10 gives 0x4E, 18 gives 0x8E, 34 gives 0xCE. The value 0 selects the default of 10.
- R7: Any other acq_sel_i value makes err_o pulse after the status check, with no acquisition command sent.
- R8: When reduced_i is high, every byte sent is rewritten as {bits 7:6, bits 3:0, 2'b00}. For example, 0x08 becomes 0x20, 0x0C becomes 0x30 and 0x4E becomes 0x78.
- R9: done_o and err_o are single-cycle pulses, and exactly one of them occurs per run. start_i is ignored while a run is in progress and in the cycle of the done or error pulse.
- R10: While spi_req_o is high and spi_ack_i is low, spi_byte_o and spi_last_o stay stable. Each acknowledge consumes exactly one byte.
- R11: acq_sel_i and reduced_i are sampled in the cycle start_i is accepted, and later changes to them have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calibration and setup run |
| acq_sel_i | input | SEL_W | Acquisition time in conversion-clock periods (0 selects the default) |
| reduced_i | input | 1 | High selects the reduced-channel command layout |
| eoc_i | input | 1 | End-of-conversion line from the converter |
| spi_req_o | output | 1 | A byte is presented to the shifter |
| spi_byte_o | output | 8 | Byte to shift out |
| spi_last_o | output | 1 | The presented byte ends its frame |
| spi_ack_i | input | 1 | One-cycle pulse: presented byte shifted, spi_rx_i valid |
| spi_rx_i | input | 8 | Byte received during the acknowledged transfer |
| done_o | output | 1 | One-cycle pulse: run completed |
| err_o | output | 1 | One-cycle pulse: run aborted |

## Verification
The bench builds the block with TIMEOUT_CYC set to 64 and the default two-stage synchronizer on the end-of-conversion line. The short timeout makes the timeout path reachable within a few dozen cycles, so the bench can check the exact distance between the dummy read and the second status read. It also runs cases where an early end-of-conversion pulse cuts the wait short. A scoreboard checks the byte stream against expected bytes for every acquisition code, for both variants, for calibration-busy and unsupported selections, and for start held high through a whole run.

// File: rtl/ais_pkg.sv
package ais_pkg;

  localparam logic [7:0] CMD_SELF_CAL  = 8'h08;
  localparam logic [7:0] CMD_STAT_RD   = 8'h0C;
  localparam logic [7:0] CMD_PAD       = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CAL,
    S_DUM_HI,
    S_DUM_LO,
    S_WAIT,
    S_STAT_HI,
    S_STAT_LO,
    S_CHECK,
    S_ACQ,
    S_DONE,
    S_FAIL
  } seq_state_e;

  // reduced-channel layout: keep [7:6], move [3:0] up to [5:2]
  function automatic logic [7:0] remap_reduced(input logic [7:0] b);
    return {b[7:6], b[3:0], 2'b00};
  endfunction

  function automatic logic is_xfer(input seq_state_e s);
    return (s == S_CAL) || (s == S_DUM_HI) || (s == S_DUM_LO) ||
           (s == S_STAT_HI) || (s == S_STAT_LO) || (s == S_ACQ);
  endfunction

  function automatic logic ends_frame(input seq_state_e s);
    return (s == S_CAL) || (s == S_DUM_LO) || (s == S_STAT_LO) || (s == S_ACQ);
  endfunction

endpackage

// File: rtl/ais_acq_decode.sv
module ais_acq_decode #(
  parameter int unsigned SEL_W = 6
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [7:0]       cmd_o,
  output logic             ok_o
);

  localparam logic [SEL_W-1:0] SEL_DEF = '0;
  localparam logic [SEL_W-1:0] SEL_6   = SEL_W'(6);
  localparam logic [SEL_W-1:0] SEL_10  = SEL_W'(10);
  localparam logic [SEL_W-1:0] SEL_18  = SEL_W'(18);
  localparam logic [SEL_W-1:0] SEL_34  = SEL_W'(34);

  always_comb begin
    cmd_o = 8'h00;
    ok_o  = 1'b1;
    if (sel_i == SEL_6)                           cmd_o = 8'h0E;
    else if (sel_i == SEL_10 || sel_i == SEL_DEF) cmd_o = 8'h4E;
    else if (sel_i == SEL_18)                     cmd_o = 8'h8E;
    else if (sel_i == SEL_34)                     cmd_o = 8'hCE;
    else                                          ok_o  = 1'b0;
  end

endmodule

// File: rtl/ais_eoc_wait.sv
module ais_eoc_wait #(
  parameter int unsigned TIMEOUT_CYC = 10_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic eoc_i,
  output logic fire_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          eoc_s;
  logic          eoc_prev_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign eoc_s = eoc_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], eoc_i} >> 0;
      end
      assign eoc_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  assign rise   = eoc_s & ~eoc_prev_q;
  assign fire_o = en_i & (rise | (cnt_q == LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_prev_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      eoc_prev_q <= eoc_s;
      if (en_i && !fire_o) cnt_q <= cnt_q + 1'b1;
      else                 cnt_q <= '0;
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (cnt_q <= LAST)) else $error("wait counter overran"); // R4

endmodule

// File: rtl/ais_status_cap.sv
module ais_status_cap (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_hi_i,
  input  logic       cap_lo_i,
  input  logic [7:0] rx_i,
  output logic       cal_busy_o
);

  logic [7:0] hi_q;
  logic [8:0] status_q;
  logic       unused_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      status_q <= '0;
    end else begin
      if (cap_hi_i) hi_q <= rx_i;
      if (cap_lo_i) status_q <= {hi_q, rx_i[7]};
    end
  end

  assign cal_busy_o  = status_q[6];
  assign unused_bits = ^{status_q[8:7], status_q[5:0], rx_i[6:0]};

endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
  import ais_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 10_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SEL_W-1:0] acq_sel_i,
  input  logic             reduced_i,
  input  logic             eoc_i,
  output logic             spi_req_o,
  output logic [7:0]       spi_byte_o,
  output logic             spi_last_o,
  input  logic             spi_ack_i,
  input  logic [7:0]       spi_rx_i,
  output logic             done_o,
  output logic             err_o
);

  seq_state_e       state_q, state_n;
  logic             red_q;
  logic [SEL_W-1:0] sel_q;
  logic             wait_fire;
  logic             cal_busy;
  logic             acq_ok;
  logic [7:0]       acq_cmd;
  logic             red_eff;
  logic [7:0]       raw_n, byte_n;
  logic             req_q, last_q, done_q, err_q;
  logic [7:0]       byte_q;

  ais_acq_decode #(.SEL_W(SEL_W)) u_acq (
    .sel_i (sel_q),
    .cmd_o (acq_cmd),
    .ok_o  (acq_ok)
  );

  ais_eoc_wait #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_wait (
    .clk    (clk),
    .rst    (rst),
    .en_i   (state_q == S_WAIT),
    .eoc_i  (eoc_i),
    .fire_o (wait_fire)
  );

  ais_status_cap u_stat (
    .clk        (clk),
    .rst        (rst),
    .cap_hi_i   ((state_q == S_STAT_HI) && spi_ack_i),
    .cap_lo_i   ((state_q == S_STAT_LO) && spi_ack_i),
    .rx_i       (spi_rx_i),
    .cal_busy_o (cal_busy)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i)   state_n = S_CAL;
      S_CAL:     if (spi_ack_i) state_n = S_DUM_HI;
      S_DUM_HI:  if (spi_ack_i) state_n = S_DUM_LO;
      S_DUM_LO:  if (spi_ack_i) state_n = S_WAIT;
      S_WAIT:    if (wait_fire) state_n = S_STAT_HI;
      S_STAT_HI: if (spi_ack_i) state_n = S_STAT_LO;
      S_STAT_LO: if (spi_ack_i) state_n = S_CHECK;
      S_CHECK: begin
        if (cal_busy || !acq_ok) state_n = S_FAIL;
        else                     state_n = S_ACQ;
      end
      S_ACQ:     if (spi_ack_i) state_n = S_DONE;
      S_DONE:    state_n = S_IDLE;
      S_FAIL:    state_n = S_IDLE;
      default:   state_n = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_n)
      S_CAL:                raw_n = CMD_SELF_CAL;
      S_DUM_HI, S_STAT_HI:  raw_n = CMD_STAT_RD;
      S_ACQ:                raw_n = acq_cmd;
      default:              raw_n = CMD_PAD;
    endcase
  end

  assign red_eff = (state_q == S_IDLE) ? reduced_i : red_q;
  assign byte_n  = red_eff ? remap_reduced(raw_n) : raw_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      red_q   <= 1'b0;
      sel_q   <= '0;
      req_q   <= 1'b0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_q == S_IDLE && start_i) begin
        red_q <= reduced_i;
        sel_q <= acq_sel_i;
      end
      req_q  <= is_xfer(state_n);
      byte_q <= byte_n;
      last_q <= ends_frame(state_n);
      done_q <= (state_n == S_DONE);
      err_q  <= (state_n == S_FAIL);
    end
  end

  assign spi_req_o  = req_q;
  assign spi_byte_o = byte_q;
  assign spi_last_o = last_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_byte_o) && $stable(spi_last_o)))
    else $error("byte changed before acknowledge"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o) else $error("error longer than one cycle"); // R9
  AST_NO_XFER_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !spi_req_o) else $error("byte requested during abort"); // R7
  AST_ACQ_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ACQ && !red_q) |-> (spi_byte_o[3:0] == 4'hE))
    else $error("acquisition command malformed"); // R6
  AST_REMAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (spi_req_o && red_q) |-> (spi_byte_o[1:0] == 2'b00))
    else $error("reduced layout low bits set"); // R8

endmodule

// File: tb/adc_init_seq_tb.sv
`timescale 1ns/1ps
module adc_init_seq_tb;

  localparam int LIM = 64;

  typedef struct packed {
    logic [7:0] tx;
    logic       last;
    logic [7:0] rx;
    logic [7:0] eocd;
    logic [1:0] gapk;
  } xfer_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [5:0] acq_sel_i = '0;
  logic       reduced_i = 1'b0;
  logic       eoc_i = 1'b0;
  logic       spi_req_o, spi_last_o, spi_ack_i, done_o, err_o;
  logic [7:0] spi_byte_o, spi_rx_i;

  int n_chk = 0, n_bad = 0, cyc = 0, n_done = 0, n_err = 0;
  xfer_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_init_seq #(.TIMEOUT_CYC(LIM), .SYNC_STAGES(2), .SEL_W(6)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .acq_sel_i(acq_sel_i),
    .reduced_i(reduced_i), .eoc_i(eoc_i), .spi_req_o(spi_req_o),
    .spi_byte_o(spi_byte_o), .spi_last_o(spi_last_o), .spi_ack_i(spi_ack_i),
    .spi_rx_i(spi_rx_i), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rm(input logic [7:0] b, input logic red);
    return red ? {b[7:6], b[3:0], 2'b00} : b;
  endfunction

  function automatic logic [7:0] acq_code(input logic [5:0] s);
    case (s)
      6'd0, 6'd10: return 8'h4E;
      6'd6:        return 8'h0E;
      6'd18:       return 8'h8E;
      6'd34:       return 8'hCE;
      default:     return 8'h00;
    endcase
  endfunction

  task automatic push(input logic [7:0] tx, input logic last, input logic [7:0] rx,
                      input logic [7:0] eocd, input logic [1:0] gapk);
    xfer_t it;
    it.tx = tx; it.last = last; it.rx = rx; it.eocd = eocd; it.gapk = gapk;
    exp_q.push_back(it);
  endtask

  // monitor / shifter model: pops expected bytes and compares
  initial begin
    xfer_t it;
    int seen, last_ack;
    spi_ack_i = 1'b0;
    spi_rx_i  = 8'h00;
    last_ack  = 0;
    forever begin
      @(negedge clk);
      spi_ack_i = 1'b0;
      if (!rst && spi_req_o) begin
        seen = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected byte", spi_byte_o, 0);
          it = '0;
        end else begin
          it = exp_q.pop_front();
          chk(spi_byte_o == it.tx, "R2/R6/R8", "byte", spi_byte_o, it.tx);
          chk(spi_last_o == it.last, "R2", "frame end flag", spi_last_o, it.last);
          if (it.gapk == 2'd1)
            chk(seen - last_ack == LIM + 1, "R4", "timeout gap", seen - last_ack, LIM + 1);
          if (it.gapk == 2'd2)
            chk(seen - last_ack < LIM + 1, "R4", "early eoc gap", seen - last_ack, LIM);
        end
        repeat (2) @(negedge clk);
        chk(spi_req_o && spi_byte_o == it.tx, "R10", "held byte", spi_byte_o, it.tx);
        spi_rx_i  = it.rx;
        spi_ack_i = 1'b1;
        last_ack  = cyc;
        if (it.eocd != 0) begin
          @(negedge clk);
          spi_ack_i = 1'b0;
          repeat (int'(it.eocd) - 1) @(negedge clk);
          eoc_i = 1'b1;
          @(negedge clk);
          eoc_i = 1'b0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_o) n_done++;
      if (err_o)  n_err++;
    end
  end

  task automatic run_case(input string name, input logic [5:0] sel, input logic red,
                          input logic [7:0] dum, input logic [7:0] st0,
                          input logic [7:0] st1, input int eocd,
                          input bit hold, input bit exp_err, input bit acq_sent);
    logic [7:0] stb;
    stb = rm(8'h0C, red);
    push(rm(8'h08, red), 1'b1, 8'h00, 8'd0, 2'd0);
    push(stb, 1'b0, dum, 8'd0, 2'd0);
    push(8'h00, 1'b1, 8'hA5, 8'(eocd), 2'd0);
    push(stb, 1'b0, st0, 8'd0, (eocd == 0) ? 2'd1 : 2'd2);
    push(8'h00, 1'b1, st1, 8'd0, 2'd0);
    if (acq_sent) push(rm(acq_code(sel), red), 1'b1, 8'h00, 8'd0, 2'd0);
    n_done = 0;
    n_err  = 0;
    @(negedge clk);
    acq_sel_i = sel; reduced_i = red; start_i = 1'b1;
    @(negedge clk);
    if (!hold) start_i = 1'b0;
    acq_sel_i = ~sel; reduced_i = ~red;   // R11: changes after start must not matter
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_o || err_o) begin start_i = 1'b0; break; end
    end
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    $display("case %s", name);
    chk(exp_q.size() == 0, "R2/R11", "bytes still expected", exp_q.size(), 0);
    chk(n_done == (exp_err ? 0 : 1), "R9", "done pulses", n_done, exp_err ? 0 : 1);
    chk(n_err == (exp_err ? 1 : 0), "R5/R7", "error pulses", n_err, exp_err ? 1 : 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!spi_req_o, "R1", "req after reset", spi_req_o, 0);
    chk(!done_o && !err_o, "R1", "pulses after reset", {done_o, err_o}, 0);
    repeat (5) @(negedge clk);
    chk(!spi_req_o, "R1", "req while idle", spi_req_o, 0);

    run_case("default sel, timeout", 6'd0,  1'b0, 8'h00, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b1); // R2 R4 R6
    run_case("sel 6, early eoc",     6'd6,  1'b0, 8'h00, 8'h00, 8'h00, 5, 1'b0, 1'b0, 1'b1); // R4 R6
    run_case("sel 10",               6'd10, 1'b0, 8'h00, 8'h00, 8'h00, 3, 1'b0, 1'b0, 1'b1); // R6
    run_case("sel 18 reduced",       6'd18, 1'b1, 8'h00, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b1); // R8
    run_case("sel 34 reduced",       6'd34, 1'b1, 8'h00, 8'h00, 8'h00, 4, 1'b0, 1'b0, 1'b1); // R8
    run_case("dummy says busy",      6'd10, 1'b0, 8'hFF, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b1); // R3
    run_case("cal busy",             6'd10, 1'b0, 8'h00, 8'h20, 8'h00, 0, 1'b0, 1'b1, 1'b0); // R5
    run_case("other status bits",    6'd6,  1'b0, 8'h00, 8'hDF, 8'hFF, 2, 1'b0, 1'b0, 1'b1); // R5
    run_case("cal busy reduced",     6'd34, 1'b1, 8'h00, 8'h3F, 8'h80, 0, 1'b0, 1'b1, 1'b0); // R5 R8
    run_case("bad sel 7",            6'd7,  1'b0, 8'h00, 8'h00, 8'h00, 0, 1'b0, 1'b1, 1'b0); // R7
    run_case("bad sel 63 reduced",   6'd63, 1'b1, 8'h00, 8'h00, 8'h00, 3, 1'b0, 1'b1, 1'b0); // R7
    run_case("start held",           6'd18, 1'b0, 8'h00, 8'h00, 8'h00, 0, 1'b1, 1'b0, 1'b1); // R9

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_bad);
    $finish;
  end

endmodule